// File: doc/BRIEF.md
# Inbound Widget Device Access Filter

This block decides, one request at a time, whether a request arriving from an I/O widget may enter the hub. Each request carries a source widget number, a device number and a flag that marks it as a reply. Widget 0 and widgets 8 to 15 each have one enable bit in a widget-enable register. Widgets 8 to 15 also have eight device-enable bits each, one for every DMA master behind that widget. These bits sit in a 64-bit device-enable register. A non-reply request is accepted only when every enable bit that covers it is set. Replies always pass.

Software updates both registers through a simple write port. The widget-enable register is loaded directly by a write. The device-enable register can only be set by software: a written 1 sets a bit and a written 0 leaves it alone. Hardware clears a device bit when an error-detect pulse names that widget and device. This lets a misbehaving DMA master be fenced off without affecting its neighbours. Software can re-enable it later.

The verdict is registered. It appears, with a valid strobe, in the cycle after the request is presented. The verdict is taken from the register contents in force when the request is sampled. A register write or an error pulse takes effect for requests sampled from the following clock edge. The block is pure datapath plus two registers. It has no sequencing states and no transitions.

Top module: `iwf_inbound_filter`

## Requirements
- R1: `resp_vld` is high in exactly the cycle after a cycle with `req_vld` high. `resp_accept` carries the verdict for that request.
- R2: A non-reply request from a widget w in 8..15, device d, is accepted if and only if widget-enable bit w is set and device-enable bit (w-8)*8+d is set. Widget 8 owns device bits 7:0 and widget 15 owns bits 63:56.
- R3: A non-reply request from widget 0 is accepted if and only if widget-enable bit 0 is set. The device number is not consulted.
- R4: An error pulse (`err_vld`) naming widget w in 8..15 and device d clears device-enable bit (w-8)*8+d. An error pulse naming widget 0..7 changes no bit.
- R5: A write with `cfg_sel`=1 sets each device-enable bit whose `cfg_wdata` bit is 1. Bits written 0 keep their value. No device bit is ever set without such a write.
- R6: A request with `req_is_reply`=1 is accepted whatever the enable state.
- R7: A non-reply request from widgets 1..7 is always rejected.
- R8: A write with `cfg_sel`=0 loads widget-enable bits 0 and 15:8 from `cfg_wdata` bits 0 and 15:8. Widget-enable bits 7:1 stay zero whatever is written.
- R9: If an error clear and a software set hit the same device bit in the same cycle, the bit ends cleared.
- R10: After reset, widget-enable bits 0 and 15:8 and all 64 device-enable bits are 1, and `resp_vld`/`resp_accept` are 0. A register update takes effect for requests sampled one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Inbound request present |
| req_widget | input | 4 | Source widget number |
| req_dev | input | 3 | Source device number within widget |
| req_is_reply | input | 1 | Request is a reply packet |
| err_vld | input | 1 | Error detected, disable named device |
| err_widget | input | 4 | Widget of device to disable |
| err_dev | input | 3 | Device to disable |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = widget-enable register, 1 = device-enable register |
| cfg_wdata | input | 64 | Write data |
| resp_vld | output | 1 | Verdict valid |
| resp_accept | output | 1 | 1 = accept, 0 = reject |

## Verification
The bench checks that an error aimed at one device leaves the neighbouring device bit intact. A wrong field index would fence the wrong master. An error naming a low widget must not wrap into a high widget's field, and the bench probes the device bit such a wrap would hit. Zero-valued device writes are tested to confirm they do not clear bits, which a plain-load register would do. A reserved widget bit written to 1 must not admit widgets 1..7. The bench also collides a set and a clear on one bit in one cycle, where set-wins logic would leave the device enabled.

// File: rtl/iwf_pkg.sv
package iwf_pkg;
    typedef enum logic {
        SEL_WIDGET = 1'b0,
        SEL_DEVICE = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/iwf_widget_en.sv
module iwf_widget_en #(
    parameter int NUM_WID  = 16,
    parameter int FIRST_HI = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_WID-1:0] wdata,
    output logic [NUM_WID-1:0] wid_en
);
    // Bit 0 and bits FIRST_HI and above are real flops; the rest are reserved zeros.
    for (genvar g = 0; g < NUM_WID; g++) begin : g_bit
        if (g == 0 || g >= FIRST_HI) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n)     wid_en[g] <= 1'b1;
                else if (wr_en) wid_en[g] <= wdata[g];
            end
        end else begin : g_rsvd
            assign wid_en[g] = 1'b0;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wid_en[FIRST_HI-1:1] == '0); // R8
endmodule

// File: rtl/iwf_device_en.sv
module iwf_device_en #(
    parameter int NUM_WID  = 16,
    parameter int NUM_HI   = 8,
    parameter int DEVS     = 8,
    localparam int WID_W    = $clog2(NUM_WID),
    localparam int DEV_W    = $clog2(DEVS),
    localparam int HI_W     = $clog2(NUM_HI),
    localparam int DEV_BITS = NUM_HI * DEVS,
    localparam int FIRST_HI = NUM_WID - NUM_HI
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [DEV_BITS-1:0] set_mask,
    input  logic                err_vld,
    input  logic [WID_W-1:0]    err_widget,
    input  logic [DEV_W-1:0]    err_dev,
    output logic [DEV_BITS-1:0] dev_en
);
    localparam int IDX_W = HI_W + DEV_W;

    logic [WID_W-1:0]    rel;
    logic                clr_hit;
    logic [IDX_W-1:0]    clr_idx;
    logic [DEV_BITS-1:0] nxt;

    assign rel     = err_widget - WID_W'(FIRST_HI);
    assign clr_hit = err_vld && (err_widget >= WID_W'(FIRST_HI));
    assign clr_idx = {rel[HI_W-1:0], err_dev};

    always_comb begin
        for (int i = 0; i < DEV_BITS; i++) begin
            nxt[i] = (dev_en[i] | (set_en & set_mask[i]))
                     & ~(clr_hit && (clr_idx == IDX_W'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dev_en <= '1;
        else        dev_en <= nxt;
    end

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !set_en) |=> !dev_en[$past(clr_idx)]); // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && set_en) |=> !dev_en[$past(clr_idx)]); // R9
    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en |=> ((dev_en & ~$past(dev_en)) == '0)); // R5
endmodule

// File: rtl/iwf_decide.sv
module iwf_decide #(
    parameter int NUM_WID  = 16,
    parameter int NUM_HI   = 8,
    parameter int DEVS     = 8,
    localparam int WID_W    = $clog2(NUM_WID),
    localparam int DEV_W    = $clog2(DEVS),
    localparam int HI_W     = $clog2(NUM_HI),
    localparam int DEV_BITS = NUM_HI * DEVS,
    localparam int FIRST_HI = NUM_WID - NUM_HI
) (
    input  logic                is_reply,
    input  logic [WID_W-1:0]    widget,
    input  logic [DEV_W-1:0]    dev,
    input  logic [NUM_WID-1:0]  wid_en,
    input  logic [DEV_BITS-1:0] dev_en,
    output logic                accept
);
    logic [WID_W-1:0]        rel;
    logic [HI_W+DEV_W-1:0]   idx;

    assign rel = widget - WID_W'(FIRST_HI);
    assign idx = {rel[HI_W-1:0], dev};

    always_comb begin
        if (is_reply)                          accept = 1'b1;
        else if (widget == '0)                 accept = wid_en[0];
        else if (widget >= WID_W'(FIRST_HI))   accept = wid_en[widget] & dev_en[idx];
        else                                   accept = 1'b0;
    end
endmodule

// File: rtl/iwf_inbound_filter.sv
module iwf_inbound_filter #(
    parameter int NUM_WID = 16,
    parameter int NUM_HI  = 8,
    parameter int DEVS    = 8,
    parameter int CFG_W   = 64,
    localparam int WID_W    = $clog2(NUM_WID),
    localparam int DEV_W    = $clog2(DEVS),
    localparam int DEV_BITS = NUM_HI * DEVS,
    localparam int FIRST_HI = NUM_WID - NUM_HI
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [WID_W-1:0] req_widget,
    input  logic [DEV_W-1:0] req_dev,
    input  logic             req_is_reply,
    input  logic             err_vld,
    input  logic [WID_W-1:0] err_widget,
    input  logic [DEV_W-1:0] err_dev,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             resp_vld,
    output logic             resp_accept
);
    import iwf_pkg::*;

    logic [NUM_WID-1:0]  wid_en;
    logic [DEV_BITS-1:0] dev_en;
    logic                wr_wid, wr_dev, verdict;

    assign wr_wid = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_WIDGET);
    assign wr_dev = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_DEVICE);

    iwf_widget_en #(.NUM_WID(NUM_WID), .FIRST_HI(FIRST_HI)) u_wid (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_wid),
        .wdata(cfg_wdata[NUM_WID-1:0]), .wid_en(wid_en)
    );

    iwf_device_en #(.NUM_WID(NUM_WID), .NUM_HI(NUM_HI), .DEVS(DEVS)) u_dev (
        .clk(clk), .rst_n(rst_n), .set_en(wr_dev),
        .set_mask(cfg_wdata[DEV_BITS-1:0]), .err_vld(err_vld),
        .err_widget(err_widget), .err_dev(err_dev), .dev_en(dev_en)
    );

    iwf_decide #(.NUM_WID(NUM_WID), .NUM_HI(NUM_HI), .DEVS(DEVS)) u_dec (
        .is_reply(req_is_reply), .widget(req_widget), .dev(req_dev),
        .wid_en(wid_en), .dev_en(dev_en), .accept(verdict)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_vld    <= 1'b0;
            resp_accept <= 1'b0;
        end else begin
            resp_vld    <= req_vld;
            resp_accept <= req_vld && verdict;
        end
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> resp_vld); // R1
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !resp_vld); // R1
    AST_REPLY_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_is_reply) |=> resp_accept); // R6
    AST_LOW_WID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_is_reply && req_widget != '0 && req_widget < WID_W'(FIRST_HI))
        |=> !resp_accept); // R7
endmodule

// File: tb/tb_iwf_inbound_filter.sv
module tb_iwf_inbound_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 0, req_is_reply = 0, err_vld = 0, cfg_wr = 0, cfg_sel = 0;
    logic [3:0]  req_widget = 0, err_widget = 0;
    logic [2:0]  req_dev = 0, err_dev = 0;
    logic [63:0] cfg_wdata = 0;
    logic        resp_vld, resp_accept;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    iwf_inbound_filter dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_widget(req_widget),
        .req_dev(req_dev), .req_is_reply(req_is_reply), .err_vld(err_vld),
        .err_widget(err_widget), .err_dev(err_dev), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .resp_vld(resp_vld),
        .resp_accept(resp_accept)
    );

    // {reply, widget[3:0], dev[2:0], expected accept}, all from reset state
    localparam logic [8:0] VEC [10] = '{
        {1'b0, 4'd0,  3'd0, 1'b1},  // R3
        {1'b0, 4'd3,  3'd2, 1'b0},  // R7
        {1'b0, 4'd7,  3'd7, 1'b0},  // R7
        {1'b0, 4'd8,  3'd0, 1'b1},  // R2
        {1'b0, 4'd15, 3'd7, 1'b1},  // R2
        {1'b1, 4'd5,  3'd1, 1'b1},  // R6
        {1'b0, 4'd12, 3'd4, 1'b1},  // R2
        {1'b0, 4'd1,  3'd0, 1'b0},  // R7
        {1'b1, 4'd9,  3'd3, 1'b1},  // R6
        {1'b0, 4'd10, 3'd6, 1'b1}   // R2
    };

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_req(logic rp, logic [3:0] w, logic [2:0] d, logic exp, string tag);
        @(negedge clk);
        req_vld = 1; req_is_reply = rp; req_widget = w; req_dev = d;
        @(negedge clk);
        req_vld = 0; req_is_reply = 0;
        chk({tag, " valid"}, resp_vld, 1'b1);
        chk(tag, resp_accept, exp);
    endtask

    task automatic do_cfg(logic sel, logic [63:0] data);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 0; cfg_wdata = 0;
    endtask

    task automatic do_err(logic [3:0] w, logic [2:0] d, logic also_set, logic [63:0] data);
        @(negedge clk);
        err_vld = 1; err_widget = w; err_dev = d;
        cfg_wr = also_set; cfg_sel = 1; cfg_wdata = data;
        @(negedge clk);
        err_vld = 0; cfg_wr = 0; cfg_wdata = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset valid", resp_vld, 1'b0);
        chk("R10 reset accept", resp_accept, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle no valid", resp_vld, 1'b0);

        for (int i = 0; i < 10; i++) begin
            do_req(VEC[i][8], VEC[i][7:4], VEC[i][3:1], VEC[i][0], "R10 reset table");
        end

        do_err(4'd9, 3'd3, 0, 64'd0);
        do_req(0, 4'd9, 3'd3, 0, "R4 cleared device");
        do_req(0, 4'd9, 3'd2, 1, "R4 neighbour kept");

        do_err(4'd5, 3'd0, 0, 64'd0);
        do_req(0, 4'd13, 3'd0, 1, "R4 low widget error no wrap");

        do_cfg(1, 64'd0);
        do_req(0, 4'd9, 3'd2, 1, "R5 zero write keeps set");
        do_req(0, 4'd9, 3'd3, 0, "R5 zero write keeps clear");
        do_cfg(1, 64'd1 << 11);
        do_req(0, 4'd9, 3'd3, 1, "R5 write one sets");

        do_cfg(0, 64'h0000_FBFE);
        do_req(0, 4'd0, 3'd5, 0, "R3 widget0 disabled");
        do_req(0, 4'd10, 3'd1, 0, "R2 widget bit off");
        do_req(0, 4'd11, 3'd1, 1, "R2 other widget on");
        do_req(1, 4'd10, 3'd1, 1, "R6 reply bypass");
        do_req(0, 4'd3, 3'd0, 0, "R8 reserved bit ignored");
        do_cfg(0, 64'h0000_FFFF);
        do_req(0, 4'd0, 3'd2, 1, "R3 widget0 reenabled");
        do_req(0, 4'd10, 3'd1, 1, "R8 widget bit reloaded");

        do_err(4'd14, 3'd5, 1, 64'd1 << 53);
        do_req(0, 4'd14, 3'd5, 0, "R9 clear beats set");
        do_req(0, 4'd14, 3'd4, 1, "R9 neighbour kept");

        // write at one edge, request sampled at the very next edge
        @(negedge clk);
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 64'd1 << 53;
        @(negedge clk);
        cfg_wr = 0; cfg_wdata = 0;
        req_vld = 1; req_widget = 4'd14; req_dev = 3'd5; req_is_reply = 0;
        @(negedge clk);
        req_vld = 0;
        chk("R10 update visible next cycle", resp_accept, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule